// File: doc/BRIEF.md
# Video Capture Buffer with Half-Full Block Drain

This block sits between a video source and a host processor. Each cycle of the pixel clock can push one 32-bit word into it. The host reads it through a single active-low select strobe with no address. Internal ring pointers place each word and take each one back out in arrival order, so neither side ever sees an address.

An active-low half-full flag interrupts the host. The host answers by draining exactly half the depth. It reads one word per strobe, in bursts with idle gaps of any length between them. Because the drain is never larger than what the flag guarantees is stored, the host does not run the buffer dry.

The host strobe is not related to the capture clock. A short synchroniser carries it into the single clock domain, and an edge detector turns each strobe into exactly one read. Full and empty flags guard the two ends of the buffer. Sticky bits record a word dropped on a full buffer and a read attempted on an empty one. A synchronous reset empties the buffer and clears every flag.

Top module: `vid_capture_fifo`

## Requirements
- R1: For the cycle after a synchronous reset, `empty` is 1, `full` is 0, `half_full_n` is 1, `overflow` and `underflow` are 0 and `rd_data` is 0, whatever the buffer held before.
- R2: Words are read back in the order they were accepted, including across the wrap of the internal pointers.
- R3: A write while `full` is 1 is discarded, and the stored words stay intact. The write sets `overflow`, which stays at 1 until reset.
- R4: A read strobe while `empty` is 1 leaves `rd_data` unchanged. It sets `underflow`, which stays at 1 until reset.
- R5: `empty` is 1 exactly when occupancy is zero, and it changes on the same clock edge that accepts the write or read.
- R6: `half_full_n` is 0 while occupancy is at least DEPTH/2. It returns to 1 on the edge where a read takes occupancy below DEPTH/2.
- R7: `full` is 1 exactly when occupancy equals DEPTH.
- R8: Each high-to-low transition of `rd_sel_n` removes exactly one word, however long the line stays low. The word appears on `rd_data` at the third rising clock edge after the transition.
- R9: A write and a read on the same edge are both performed, and occupancy is unchanged.
- R10: After `half_full_n` falls, the host drains DEPTH/2 words in bursts with idle gaps between them. This raises no underflow and, if no further writes arrive, leaves the buffer empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock; every register uses it |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one word |
| wr_data | input | DATA_W | Word to store |
| rd_sel_n | input | 1 | Active-low host select used as the read strobe; asynchronous to clk |
| rd_data | output | DATA_W | Most recently read word (registered) |
| full | output | 1 | Occupancy equals DEPTH |
| half_full_n | output | 1 | Active low; occupancy at least DEPTH/2 |
| empty | output | 1 | Occupancy is zero |
| overflow | output | 1 | Sticky: a write was dropped on a full buffer |
| underflow | output | 1 | Sticky: a read arrived at an empty buffer |

## Verification
The bench targets the threshold crossings in both directions. A design that compares against the wrong level, or only updates the flag on writes, would leave `half_full_n` low after a drain or raise it one word late.

It fills past capacity. A design that accepts the extra word would corrupt the oldest entry or shift the read order across the pointer wrap. It also holds the select line low for many cycles, which would drain several words from a level-sensitive design instead of one.

Finally, it lines a write up with a read on the same edge, reads an empty buffer, and resets a loaded buffer mid-run. These catch lost updates, a changed `rd_data` on underflow, and stale flags after reset.

// File: rtl/vcf_pkg.sv
package vcf_pkg;
  typedef struct packed {
    logic full;
    logic half_n;
    logic empty;
    logic ovf;
    logic unf;
  } vcf_flags_t;
endpackage

// File: rtl/vcf_strobe_sync.sv
module vcf_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic rd_pulse
);
  // sh[0..STAGES-1] synchronise, sh[STAGES] holds the previous level
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh[0] <= 1'b1;
    else     sh[0] <= strobe_n;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) sh[g] <= 1'b1;
      else     sh[g] <= sh[g-1];
    end
  end

  // falling edge of the synchronised strobe: one pulse per host access
  assign rd_pulse = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/vcf_ram.sv
module vcf_ram #(
  parameter int DATA_W = 32,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port; output holds when no read is granted
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vcf_ctrl.sv
module vcf_ctrl
  import vcf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output vcf_flags_t    flags
);
  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);

  logic [CW-1:0] occ, occ_nxt;

  assign wr_ok = wr_req & ~flags.full;
  assign rd_ok = rd_req & ~flags.empty;

  always_comb begin
    occ_nxt = occ + {{(CW-1){1'b0}}, wr_ok} - {{(CW-1){1'b0}}, rd_ok};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ          <= '0;
      waddr        <= '0;
      raddr        <= '0;
      flags.full   <= 1'b0;
      flags.half_n <= 1'b1;
      flags.empty  <= 1'b1;
      flags.ovf    <= 1'b0;
      flags.unf    <= 1'b0;
    end else begin
      occ          <= occ_nxt;
      if (wr_ok) waddr <= waddr + 1'b1;
      if (rd_ok) raddr <= raddr + 1'b1;
      flags.full   <= (occ_nxt == LVL_FULL);
      flags.half_n <= (occ_nxt < LVL_HALF);
      flags.empty  <= (occ_nxt == '0);
      flags.ovf    <= flags.ovf | (wr_req & flags.full);
      flags.unf    <= flags.unf | (rd_req & flags.empty);
    end
  end
endmodule

// File: rtl/vid_capture_fifo.sv
module vid_capture_fifo
  import vcf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              half_full_n,
  output logic              empty,
  output logic              overflow,
  output logic              underflow
);
  localparam int AW = $clog2(DEPTH);

  logic          rd_pulse, wr_ok, rd_ok;
  logic [AW-1:0] waddr, raddr;
  vcf_flags_t    flags;

  vcf_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .strobe_n(rd_sel_n), .rd_pulse(rd_pulse)
  );

  vcf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .wr_req(wr_en), .rd_req(rd_pulse),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .waddr(waddr), .raddr(raddr), .flags(flags)
  );

  vcf_ram #(.DATA_W(DATA_W), .AW(AW)) ram_i (
    .clk(clk), .rst(rst), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
    .re(rd_ok), .raddr(raddr), .rdata(rd_data)
  );

  assign full        = flags.full;
  assign half_full_n = flags.half_n;
  assign empty       = flags.empty;
  assign overflow    = flags.ovf;
  assign underflow   = flags.unf;
endmodule

// File: rtl/vcf_chk.sv
module vcf_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic full,
  input logic half_full_n,
  input logic empty,
  input logic overflow,
  input logic underflow
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty && !full && half_full_n && !overflow && !underflow));

  a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    !$fell(overflow));

  a_r3_full_write_flags: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en) |=> overflow);

  a_r4_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    !$fell(underflow));

  a_r7_full_not_empty: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  a_r6_full_means_half: assert property (@(posedge clk) disable iff (rst)
    full |-> !half_full_n);

  a_r5_empty_means_not_half: assert property (@(posedge clk) disable iff (rst)
    empty |-> half_full_n);
endmodule

bind vid_capture_fifo vcf_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .full(full), .half_full_n(half_full_n),
  .empty(empty), .overflow(overflow), .underflow(underflow)
);

// File: tb/vid_capture_fifo_tb_top.sv
module vid_capture_fifo_tb_top;
  localparam int DW    = 32;
  localparam int DEPTH = 8;
  localparam int HALF  = DEPTH / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_sel_n = 1'b1;
  logic [DW-1:0] rd_data;
  logic          full, half_full_n, empty, overflow, underflow;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vid_capture_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_sel_n(rd_sel_n),
    .rd_data(rd_data), .full(full), .half_full_n(half_full_n), .empty(empty),
    .overflow(overflow), .underflow(underflow)
  );

  // entry: {is_read, word, exp_empty, exp_half_full_n}
  localparam logic [34:0] TBL [12] = '{
    {1'b0, 32'hA000_0001, 1'b0, 1'b1},
    {1'b0, 32'hA000_0002, 1'b0, 1'b1},
    {1'b0, 32'hA000_0003, 1'b0, 1'b1},
    {1'b0, 32'hA000_0004, 1'b0, 1'b0},
    {1'b1, 32'hA000_0001, 1'b0, 1'b1},
    {1'b0, 32'hA000_0005, 1'b0, 1'b0},
    {1'b0, 32'hA000_0006, 1'b0, 1'b0},
    {1'b1, 32'hA000_0002, 1'b0, 1'b0},
    {1'b1, 32'hA000_0003, 1'b0, 1'b1},
    {1'b1, 32'hA000_0004, 1'b0, 1'b1},
    {1'b1, 32'hA000_0005, 1'b0, 1'b1},
    {1'b1, 32'hA000_0006, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pull(output logic [DW-1:0] d);
    @(negedge clk);
    rd_sel_n = 1'b0;
    repeat (3) @(negedge clk);
    d = rd_data;
    rd_sel_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", DW'(empty), 1);
    check("R1 full", DW'(full), 0);
    check("R1 half_full_n", DW'(half_full_n), 1);
    check("R1 sticky", DW'({overflow, underflow}), 0);
    check("R1 rd_data", rd_data, 0);

    // table walk: R2 order, R5 empty, R6 threshold both ways
    for (int i = 0; i < 12; i++) begin
      if (TBL[i][34]) begin
        pull(got);
        check("R2 table read", got, TBL[i][33:2]);
      end else begin
        push(TBL[i][33:2]);
      end
      check("R5 table empty", DW'(empty), DW'(TBL[i][1]));
      check("R6 table half_full_n", DW'(half_full_n), DW'(TBL[i][0]));
    end

    // R10 block drain in bursts with gaps
    for (int i = 0; i < HALF; i++) push(32'hB100_0000 + DW'(i));
    check("R10 half_full_n low", DW'(half_full_n), 0);
    for (int i = 0; i < HALF; i++) begin
      pull(got);
      check("R10 drain data", got, 32'hB100_0000 + DW'(i));
      if (i % 2 == 1) repeat (7 + 3 * i) @(negedge clk);
    end
    check("R10 empty after drain", DW'(empty), 1);
    check("R10 no underflow", DW'(underflow), 0);
    check("R10 half_full_n high", DW'(half_full_n), 1);

    // R7 full, R3 overflow, R2 wrap
    for (int i = 0; i < DEPTH; i++) begin
      push(32'hC200_0000 + DW'(i));
      check("R7 full level", DW'(full), DW'(i == DEPTH - 1));
    end
    push(32'hDEAD_BEEF);
    check("R3 overflow set", DW'(overflow), 1);
    check("R3 still full", DW'(full), 1);
    for (int i = 0; i < DEPTH; i++) begin
      pull(got);
      check("R2 R3 wrap order", got, 32'hC200_0000 + DW'(i));
    end
    check("R3 dropped word absent", DW'(empty), 1);
    check("R3 overflow sticky", DW'(overflow), 1);

    // R8 held strobe reads once
    push(32'hE300_0000);
    push(32'hE300_0001);
    @(negedge clk);
    rd_sel_n = 1'b0;
    repeat (12) @(negedge clk);
    check("R8 one word", rd_data, 32'hE300_0000);
    check("R8 not drained", DW'(empty), 0);
    rd_sel_n = 1'b1;
    repeat (3) @(negedge clk);
    pull(got);
    check("R8 next word", got, 32'hE300_0001);
    check("R8 empty", DW'(empty), 1);

    // R9 write and read on the same edge
    push(32'hF400_0000);
    push(32'hF400_0001);
    @(negedge clk);
    rd_sel_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_en = 1'b1; wr_data = 32'hF400_0002;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 read data", rd_data, 32'hF400_0000);
    rd_sel_n = 1'b1;
    repeat (3) @(negedge clk);
    pull(got);
    check("R9 second", got, 32'hF400_0001);
    check("R9 not empty", DW'(empty), 0);
    pull(got);
    check("R9 written word", got, 32'hF400_0002);
    check("R9 empty", DW'(empty), 1);

    // R4 read while empty
    pull(got);
    check("R4 data held", got, 32'hF400_0002);
    check("R4 underflow set", DW'(underflow), 1);
    check("R4 still empty", DW'(empty), 1);
    push(32'h0500_0000);
    check("R4 underflow sticky", DW'(underflow), 1);

    // R1 mid-run reset with data stored
    push(32'h0500_0001);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mid empty", DW'(empty), 1);
    check("R1 mid sticky", DW'({overflow, underflow}), 0);
    check("R1 mid rd_data", rd_data, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule